// File: doc/BRIEF.md
# Sixteen-Line GPIO Controller with Per-Line Interrupt Styles

This block is a general-purpose I/O controller for sixteen pads, reached through a 32-bit register port. Software sets the level driven on each pad and chooses, per pad, whether the pad is driven or left as an input. The current pad levels can be read back. Each pad input passes through a two-flop synchronizer before it is used. After that stage, a third flop holds the previous synchronized value, and edges are found by comparing the two.

The thirteen lowest lines can raise interrupts. Each of them has a 3-bit style field that selects one of these detections:
- active-high level
- active-low level
- rising edge
- falling edge
- any transition

A detection sets a sticky status bit. Software clears a status bit by writing 1 to it. Each status bit is also driven straight out as an active-high level interrupt toward a parent controller.

The clock-control and debounce-select registers are plain storage and do not affect the pads.

Top module: `gpio_styled_ctrl`

## Requirements
- R1: After reset, these registers read 0: output data, status, both style registers, clock control and debounce select. Output enable reads 0x0000FFFF. No pad is driven and every interrupt output is low.
- R2: Register map (byte address, word-aligned). Output data is at 0x00 and output enable is at 0x04. `pad_o` follows the output data register. `pad_oe_o[n]` is 1 exactly when output-enable bit n is 0, so an enable bit of 1 makes the line an input.
- R3: The input register at 0x08 returns the pad levels after a two-flop synchronizer. A pad change is visible on the second rising clock edge after it, and not on the first.
- R4: The status register is at 0x0C. Writing 1 to a bit clears it on the next edge. Writing 0 leaves the bit unchanged.
- R5: The level styles are 0 = active high and 1 = active low. For these styles the status bit is set on every cycle the level is active. A clear issued while the level is still active has no effect, because setting wins over clearing.
- R6: The edge styles are 2 = rising, 3 = falling and 4 = any transition. Each sets the status bit from the synchronized value and its previous value. The bit is set on the third rising edge after the pad change and stays set until it is cleared.
- R7: The style for line n < 8 is bits [3n+2:3n] of the register at 0x10. The style for line n ≥ 8 is bits [3(n−8)+2:3(n−8)] of the register at 0x14. Bits [31:24] of both style registers read 0.
- R8: Style values 5, 6 and 7 disable interrupt detection for that line. Its status bit never becomes set.
- R9: Lines 13 to 15 never set a status bit, whatever their style or pad level. Their status bits read 0.
- R10: `irq_o[n]` for lines 0 to 12 is high exactly when status bit n is set.
- R11: The clock-control register (0x18) and the debounce-select register (0x1C) are 32-bit read/write storage. Writing them does not change `pad_o` or `pad_oe_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| addr_i | input | 5 | Register byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| pad_i | input | 16 | Pad input levels, asynchronous |
| pad_o | output | 16 | Pad output levels |
| pad_oe_o | output | 16 | Pad driver enable, 1 = drive |
| irq_o | output | 13 | Level interrupts for lines 0 to 12 |

## Verification
Each result is due a fixed number of rising edges after its stimulus:
- Register writes, including status clears, take effect on the edge that samples the strobe.
- The input register follows a pad change after two edges.
- A status bit, and with it `irq_o`, follows a pad change after three edges.

The bench drives inputs on the falling clock edge and counts exactly those rising edges before it samples, half a period later. The input latency and the rising-edge latency are each probed one edge early as well, so a stage added or removed in the path is caught. Clears are tried both while a level is still active and after it has gone away, which shows that setting wins over clearing.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int STY_W = 3;

  typedef enum logic [2:0] {
    STY_HIGH = 3'd0,
    STY_LOW  = 3'd1,
    STY_RISE = 3'd2,
    STY_FALL = 3'd3,
    STY_BOTH = 3'd4
  } sty_e;

  // word indices (byte address >> 2)
  localparam int REG_DOUT   = 0;
  localparam int REG_OEN    = 1;
  localparam int REG_DIN    = 2;
  localparam int REG_STAT   = 3;
  localparam int REG_STY_LO = 4;
  localparam int REG_CLK    = 6;
  localparam int REG_DBS    = 7;
endpackage

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
  parameter int W  = 16,
  parameter int EW = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [W-1:0]  pad_i,
  output logic [W-1:0]  cur_o,
  output logic [EW-1:0] prev_o
);
  logic [W-1:0]  s1_q, s2_q;
  logic [EW-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= pad_i;
      s2_q   <= s1_q;
      prev_q <= s2_q[EW-1:0];
    end
  end

  assign cur_o  = s2_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/gpio_irq_line.sv
module gpio_irq_line
  import gpio_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cur_i,
  input  logic             prev_i,
  input  logic [STY_W-1:0] style_i,
  input  logic             clr_i,
  output logic             stat_o
);
  logic hit;
  logic stat_q;

  always_comb begin
    unique case (style_i)
      STY_HIGH: hit = cur_i;
      STY_LOW:  hit = ~cur_i;
      STY_RISE: hit = cur_i & ~prev_i;
      STY_FALL: hit = ~cur_i & prev_i;
      STY_BOTH: hit = cur_i ^ prev_i;
      default:  hit = 1'b0;
    endcase
  end

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= 1'b0;
    else         stat_q <= hit | (stat_q & ~clr_i);
  end

  assign stat_o = stat_q;

  assert_level_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (style_i == STY_HIGH && cur_i) |=> stat_o);
  assert_level_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (style_i == STY_LOW && !cur_i) |=> stat_o);
  assert_rise_edge_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (style_i == STY_RISE && cur_i && !prev_i) |=> stat_o);
  assert_fall_edge_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (style_i == STY_FALL && !cur_i && prev_i) |=> stat_o);
  assert_clear_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (style_i > STY_BOTH && clr_i) |=> !stat_o);
  assert_disabled_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (style_i > STY_BOTH && !stat_o) |=> !stat_o);
endmodule

// File: rtl/gpio_styled_ctrl.sv
module gpio_styled_ctrl
  import gpio_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int NUM_IRQ   = 13,
  parameter int DW        = 32,
  parameter int AW        = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [AW-1:0]        addr_i,
  input  logic [DW-1:0]        wdata_i,
  output logic [DW-1:0]        rdata_o,
  input  logic [NUM_LINES-1:0] pad_i,
  output logic [NUM_LINES-1:0] pad_o,
  output logic [NUM_LINES-1:0] pad_oe_o,
  output logic [NUM_IRQ-1:0]   irq_o
);
  localparam int IDX_W      = AW - 2;
  localparam int BANK_LINES = 8;
  localparam int NUM_BANKS  = NUM_LINES / BANK_LINES;

  logic [IDX_W-1:0]     widx;
  logic                 unused_addr_lsb;
  logic [NUM_LINES-1:0] dout_q, oen_q;
  logic [STY_W-1:0]     sty_q [NUM_LINES];
  logic [DW-1:0]        clk_q, dbs_q;
  logic [NUM_LINES-1:0] cur, stat;
  logic [NUM_IRQ-1:0]   prev, clr;

  assign widx            = addr_i[AW-1:2];
  assign unused_addr_lsb = ^addr_i[1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q <= '0;
      oen_q  <= '1;
      clk_q  <= '0;
      dbs_q  <= '0;
      for (int i = 0; i < NUM_LINES; i++) sty_q[i] <= '0;
    end else if (wr_en_i) begin
      if (widx == IDX_W'(REG_DOUT)) dout_q <= wdata_i[NUM_LINES-1:0];
      if (widx == IDX_W'(REG_OEN))  oen_q  <= wdata_i[NUM_LINES-1:0];
      if (widx == IDX_W'(REG_CLK))  clk_q  <= wdata_i;
      if (widx == IDX_W'(REG_DBS))  dbs_q  <= wdata_i;
      for (int i = 0; i < NUM_LINES; i++)
        if (widx == IDX_W'(REG_STY_LO + i / BANK_LINES))
          sty_q[i] <= wdata_i[(i % BANK_LINES)*STY_W +: STY_W];
    end
  end

  assign clr = (wr_en_i && widx == IDX_W'(REG_STAT)) ? wdata_i[NUM_IRQ-1:0] : '0;

  gpio_pad_sync #(.W(NUM_LINES), .EW(NUM_IRQ)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pad_i  (pad_i),
    .cur_o  (cur),
    .prev_o (prev)
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    if (i < NUM_IRQ) begin : g_irq
      gpio_irq_line u_line (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .cur_i   (cur[i]),
        .prev_i  (prev[i]),
        .style_i (sty_q[i]),
        .clr_i   (clr[i]),
        .stat_o  (stat[i])
      );
    end else begin : g_none
      assign stat[i] = 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (widx == IDX_W'(REG_DOUT)) rdata_o[NUM_LINES-1:0] = dout_q;
    if (widx == IDX_W'(REG_OEN))  rdata_o[NUM_LINES-1:0] = oen_q;
    if (widx == IDX_W'(REG_DIN))  rdata_o[NUM_LINES-1:0] = cur;
    if (widx == IDX_W'(REG_STAT)) rdata_o[NUM_LINES-1:0] = stat;
    if (widx == IDX_W'(REG_CLK))  rdata_o = clk_q;
    if (widx == IDX_W'(REG_DBS))  rdata_o = dbs_q;
    for (int b = 0; b < NUM_BANKS; b++)
      if (widx == IDX_W'(REG_STY_LO + b))
        for (int j = 0; j < BANK_LINES; j++)
          rdata_o[j*STY_W +: STY_W] = sty_q[b*BANK_LINES + j];
  end

  assign pad_o    = dout_q;
  assign pad_oe_o = ~oen_q;
  assign irq_o    = stat[NUM_IRQ-1:0];

  assert_oe_sense_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && widx == IDX_W'(REG_OEN)) |=> pad_oe_o == ~$past(wdata_i[NUM_LINES-1:0]));
  assert_store_only_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (widx == IDX_W'(REG_CLK) || widx == IDX_W'(REG_DBS)))
      |=> ($stable(pad_o) && $stable(pad_oe_o)));
endmodule

// File: tb/gpio_styled_ctrl_tb.sv
module gpio_styled_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  localparam logic [4:0] A_DOUT = 5'h00, A_OEN = 5'h04, A_DIN = 5'h08, A_STAT = 5'h0C,
                         A_STLO = 5'h10, A_STHI = 5'h14, A_CLK = 5'h18, A_DBS = 5'h1C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] pad = '0;
  logic [15:0] pad_out, pad_oe;
  logic [12:0] irq;
  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_styled_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .pad_i(pad), .pad_o(pad_out), .pad_oe_o(pad_oe), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] sty_one(input int k, input int s);
    logic [31:0] w = 32'h00FF_FFFF;
    w &= ~(32'h7 << (3*k));
    w |= (32'(s) & 32'h7) << (3*k);
    return w;
  endfunction

  function automatic logic [31:0] sty_all(input int s);
    logic [31:0] w = '0;
    for (int k = 0; k < 8; k++) w |= (32'(s) & 32'h7) << (3*k);
    return w;
  endfunction

  task automatic quiet();
    pad = '0;
    wr(A_STLO, sty_all(7));
    wr(A_STHI, sty_all(7));
    settle();
    wr(A_STAT, 32'hFFFF);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(A_DOUT, d); chk("R1 dout", d, 32'h0);
    rd(A_OEN, d);  chk("R1 oen", d, 32'h0000FFFF);
    rd(A_STAT, d); chk("R1 stat", d, 32'h0);
    rd(A_STLO, d); chk("R1 style lo", d, 32'h0);
    rd(A_CLK, d);  chk("R1 clk reg", d, 32'h0);
    chk("R1 pad_oe", 32'(pad_oe), 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
  endtask

  task automatic t_output();
    wr(A_DOUT, 32'h0000A5C3);
    wr(A_OEN, 32'h00000F0F);
    #1;
    chk("R2 pad_o", 32'(pad_out), 32'h0000A5C3);
    chk("R2 pad_oe inverted", 32'(pad_oe), 32'h0000F0F0);
  endtask

  task automatic t_input();
    logic [31:0] d;
    quiet();
    pad = 16'h5A3C;
    @(posedge clk); @(negedge clk);
    rd(A_DIN, d); chk("R3 one edge", d, 32'h0);
    @(posedge clk); @(negedge clk);
    rd(A_DIN, d); chk("R3 two edges", d, 32'h00005A3C);
    pad = '0;
  endtask

  task automatic t_level();
    logic [31:0] d;
    quiet();
    wr(A_STLO, sty_one(0, 0));
    pad = 16'h0001; settle();
    rd(A_STAT, d); chk("R5 high sets", d, 32'h1);
    chk("R10 irq0", 32'(irq), 32'h1);
    wr(A_STAT, 32'h0);
    rd(A_STAT, d); chk("R4 write0 keeps", d, 32'h1);
    wr(A_STAT, 32'h1);
    rd(A_STAT, d); chk("R5 set beats clear", d, 32'h1);
    pad = '0; settle();
    wr(A_STAT, 32'h1);
    rd(A_STAT, d); chk("R4 write1 clears", d, 32'h0);
    chk("R10 irq low", 32'(irq), 32'h0);
    wr(A_STLO, sty_one(1, 1));
    settle();
    rd(A_STAT, d); chk("R5 low sets", d, 32'h2);
    pad = 16'h0002; settle();
    wr(A_STAT, 32'h2);
    rd(A_STAT, d); chk("R5 low released clears", d, 32'h0);
  endtask

  task automatic t_edges();
    logic [31:0] d;
    quiet();
    wr(A_STLO, sty_one(3, 2));
    pad = 16'h0008;
    repeat (2) @(posedge clk); @(negedge clk);
    rd(A_STAT, d); chk("R6 rise not before 3rd edge", d, 32'h0);
    @(posedge clk); @(negedge clk);
    rd(A_STAT, d); chk("R6 rise on 3rd edge", d, 32'h8);
    pad = '0; settle();
    rd(A_STAT, d); chk("R6 rise sticky", d, 32'h8);
    wr(A_STAT, 32'h8);
    rd(A_STAT, d); chk("R6 rise cleared", d, 32'h0);

    quiet();
    wr(A_STHI, sty_one(1, 3));
    pad = 16'h0200; settle();
    rd(A_STAT, d); chk("R6 fall ignores rise", d, 32'h0);
    pad = '0; settle();
    rd(A_STAT, d); chk("R7 line9 upper field fall", d, 32'h200);
    chk("R10 irq9", 32'(irq), 32'h200);

    quiet();
    wr(A_STHI, sty_one(4, 4));
    pad = 16'h1000; settle();
    rd(A_STAT, d); chk("R6 both rise", d, 32'h1000);
    wr(A_STAT, 32'h1000);
    pad = '0; settle();
    rd(A_STAT, d); chk("R6 both fall", d, 32'h1000);
    wr(A_STAT, 32'h1000);
  endtask

  task automatic t_disable();
    logic [31:0] d;
    quiet();
    wr(A_STLO, sty_all(5));
    wr(A_STHI, sty_all(6));
    pad = 16'h1FFF; settle();
    pad = '0; settle();
    rd(A_STAT, d); chk("R8 styles 5/6 silent", d, 32'h0);
    chk("R8 irq silent", 32'(irq), 32'h0);
  endtask

  task automatic t_upper();
    logic [31:0] d;
    quiet();
    wr(A_STHI, 32'h0);
    pad = 16'hE000; settle();
    rd(A_STAT, d); chk("R9 lines 13-15 no status", d, 32'h0);
    chk("R9 irq quiet", 32'(irq), 32'h0);
    pad = '0;
  endtask

  task automatic t_style_rd();
    logic [31:0] d;
    wr(A_STLO, 32'hFFFFFFFF);
    rd(A_STLO, d); chk("R7 lo upper bits zero", d, 32'h00FFFFFF);
    wr(A_STHI, 32'h12345678);
    rd(A_STHI, d); chk("R7 hi readback", d, 32'h00345678);
  endtask

  task automatic t_storage();
    logic [31:0] d;
    logic [15:0] po, pe;
    po = pad_out; pe = pad_oe;
    wr(A_CLK, 32'hDEADBEEF);
    wr(A_DBS, 32'h13572468);
    rd(A_CLK, d); chk("R11 clk reg", d, 32'hDEADBEEF);
    rd(A_DBS, d); chk("R11 dbs reg", d, 32'h13572468);
    chk("R11 pad_o unchanged", 32'(pad_out), 32'(po));
    chk("R11 pad_oe unchanged", 32'(pad_oe), 32'(pe));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_output();
    t_input();
    t_level();
    t_edges();
    t_disable();
    t_upper();
    t_style_rd();
    t_storage();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule